// File: doc/BRIEF.md
# Timing-Error Driven Clock Frequency Tuner

This block closes a loop between timing-error detector flops at critical pipeline endpoints and the clock generator. Each endpoint raises a pulse when its data arrived late. The block first brings every pulse through a two-flop synchronizer and then through further stabilization registers. It merges the validated flags into one error indication, and it keeps a sticky history bit for each endpoint so that a diagnostic pass can later find out which flops failed.

The output frequency code is adjusted with a deliberate asymmetry. Any validated error lowers the code by one step at once. The code rises by one step only after a long run of consecutive error-free cycles. Both moves respect a floor and a ceiling that are driven in from outside. Each error also issues a one-cycle replay request to the pipeline, together with a level half-rate flag. That flag tells the clock generator to run the replay at half frequency, and it stays up until the pipeline reports that the replay has finished.

Top module: `freqTuner`

## Requirements
- R1: A one-cycle pulse on an error input reaches the outputs exactly SYNC_STAGES + STAB_STAGES + 1 clock edges after the edge that first samples it. With the defaults that is 5 edges, and no output moves earlier.
- R2: The merged error is the OR of all validated endpoint flags. Errors on several endpoints in the same cycle lower the code by one step only.
- R3: Each cycle in which the merged error is high lowers the frequency code by exactly one. Consecutive error cycles give consecutive decrements.
- R4: After CLEAN_CYCLES consecutive cycles without a merged error, the code rises by one. Any error restarts that count from zero, and the count starts again after each step-up point.
- R5: A decrement is ignored when the code is already at or below the floor input. An increment is ignored when the code is already at or above the ceiling input, and the clean count still restarts.
- R6: The replay request is high for exactly one cycle for each error cycle, and it rises at the same edge at which the code drops. It is low in every other cycle.
- R7: The half-rate flag is set together with the replay request. It stays set until a replay-done pulse arrives. If a new error and replay-done fall at the same edge, the flag stays set. Errors during a replay still lower the code.
- R8: The history bit of endpoint i (bit i of the history output) sets when that endpoint's validated error arrives, at the same edge as the code change. It then holds.
- R9: A clear-mask input clears only the history bits whose mask bit is 1, at the next edge. If a new error for that endpoint lands at the same edge, the bit stays set.
- R10: Reset sets the frequency code to INIT_CODE and drives replay request, half-rate flag, history bits and all internal pipelines to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errIn | input | NUM_EP | Raw timing-error pulses, one per endpoint |
| clrMask | input | NUM_EP | History-bit clear mask, 1 clears the bit |
| minCode | input | CODE_W | Frequency code floor |
| maxCode | input | CODE_W | Frequency code ceiling |
| replayDone | input | 1 | Pulse from the pipeline when a replay has finished |
| freqCode | output | CODE_W | Frequency setting for the clock generator |
| replayReq | output | 1 | One-cycle replay request |
| halfRate | output | 1 | Run the clock at half rate while set |
| stickyHist | output | NUM_EP | Per-endpoint error history |

## Verification
The bench builds the block with four endpoints, a 5-bit code that starts at 20, two synchronizer and two stabilization stages, and a clean run of 16 cycles instead of 1024. The short clean run puts several step-ups, a step-up blocked at the ceiling, and a count restarted by an error in the middle of a run within a few hundred cycles. The bench can then check the exact edge of each step. Keeping the default pipeline depth lets the five-edge latency, the set-wins-over-clear case and the set-wins-over-replay-done case be lined up against a known edge.

// File: rtl/tuneFreqPkg.sv
package tuneFreqPkg;
  typedef struct packed {
    logic stepDn;
    logic stepUp;
    logic cntClr;
  } tuneStrobe_t;
endpackage

// File: rtl/errFront.sv
module errFront #(
  parameter int NUM_EP      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EP-1:0] errIn,
  input  logic [NUM_EP-1:0] clrMask,
  output logic              errAny,
  output logic [NUM_EP-1:0] stickyHist
);
  localparam int DEPTH = SYNC_STAGES + STAB_STAGES;

  logic [NUM_EP-1:0] pipe [DEPTH];
  logic [NUM_EP-1:0] validated;

  // Synchronizer flops followed by the stabilization flops, one register per stage
  for (genvar s = 0; s < DEPTH; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= errIn;
      end
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign validated = pipe[DEPTH-1];
  assign errAny    = |validated;

  // Sticky history: a new error has priority over the clear mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyHist <= '0;
    else       stickyHist <= (stickyHist & ~clrMask) | validated;
  end

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(stickyHist) & ~$past(clrMask)) & ~stickyHist) == '0);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (validated != '0) |=> (stickyHist & $past(validated)) == $past(validated));
endmodule

// File: rtl/tuneCtrl.sv
module tuneCtrl
  import tuneFreqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        errAny,
  input  logic        cntAtEnd,
  input  logic        replayDone,
  output tuneStrobe_t strb,
  output logic        replayReq,
  output logic        halfRate
);
  always_comb begin
    strb.stepDn = errAny;
    strb.stepUp = !errAny && cntAtEnd;
    strb.cntClr = errAny || cntAtEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replayReq <= 1'b0;
      halfRate  <= 1'b0;
    end else begin
      replayReq <= errAny;
      if (errAny)          halfRate <= 1'b1;
      else if (replayDone) halfRate <= 1'b0;
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepDn, strb.stepUp}));

  assert_replay_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    errAny |=> (replayReq && halfRate));

  assert_replay_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !errAny |=> !replayReq);

  assert_half_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (halfRate && !replayDone) |=> halfRate);
endmodule

// File: rtl/tuneDatapath.sv
module tuneDatapath
  import tuneFreqPkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int CLEAN_CYCLES = 1024,
  parameter int INIT_CODE    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tuneStrobe_t       strb,
  input  logic [CODE_W-1:0] minCode,
  input  logic [CODE_W-1:0] maxCode,
  output logic              cntAtEnd,
  output logic [CODE_W-1:0] freqCode
);
  localparam int CNT_W = (CLEAN_CYCLES > 2) ? $clog2(CLEAN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLEAN_CYCLES - 1);

  logic [CNT_W-1:0] cleanCnt;

  assign cntAtEnd = (cleanCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cleanCnt <= '0;
    else if (strb.cntClr) cleanCnt <= '0;
    else                  cleanCnt <= cleanCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freqCode <= CODE_W'(INIT_CODE);
    else if (strb.stepDn) begin
      if (freqCode > minCode) freqCode <= freqCode - CODE_W'(1);
    end else if (strb.stepUp) begin
      if (freqCode < maxCode) freqCode <= freqCode + CODE_W'(1);
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cleanCnt <= CNT_LAST);
endmodule

// File: rtl/freqTuner.sv
module freqTuner
  import tuneFreqPkg::*;
#(
  parameter int NUM_EP       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int STAB_STAGES  = 2,
  parameter int CODE_W       = 6,
  parameter int CLEAN_CYCLES = 1024,
  parameter int INIT_CODE    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EP-1:0] errIn,
  input  logic [NUM_EP-1:0] clrMask,
  input  logic [CODE_W-1:0] minCode,
  input  logic [CODE_W-1:0] maxCode,
  input  logic              replayDone,
  output logic [CODE_W-1:0] freqCode,
  output logic              replayReq,
  output logic              halfRate,
  output logic [NUM_EP-1:0] stickyHist
);
  logic        errAny;
  logic        cntAtEnd;
  tuneStrobe_t strb;

  errFront #(.NUM_EP(NUM_EP), .SYNC_STAGES(SYNC_STAGES), .STAB_STAGES(STAB_STAGES)) uFront (
    .clk(clk), .rstN(rstN), .errIn(errIn), .clrMask(clrMask),
    .errAny(errAny), .stickyHist(stickyHist));

  tuneCtrl uCtrl (
    .clk(clk), .rstN(rstN), .errAny(errAny), .cntAtEnd(cntAtEnd),
    .replayDone(replayDone), .strb(strb), .replayReq(replayReq), .halfRate(halfRate));

  tuneDatapath #(.CODE_W(CODE_W), .CLEAN_CYCLES(CLEAN_CYCLES), .INIT_CODE(INIT_CODE)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .minCode(minCode), .maxCode(maxCode),
    .cntAtEnd(cntAtEnd), .freqCode(freqCode));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (errAny && freqCode > minCode) |=> freqCode == $past(freqCode) - CODE_W'(1));

  assert_floor_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errAny && freqCode <= minCode) |=> freqCode == $past(freqCode));
endmodule

// File: tb/freqTuner_test.sv
`timescale 1ns/1ps
module freqTuner_test;
  localparam int NEP = 4;
  localparam int CW  = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NEP-1:0] errIn = '0;
  logic [NEP-1:0] clrMask = '0;
  logic [CW-1:0]  minCode = CW'(4);
  logic [CW-1:0]  maxCode = CW'(20);
  logic           replayDone = 1'b0;
  logic [CW-1:0]  freqCode;
  logic           replayReq;
  logic           halfRate;
  logic [NEP-1:0] stickyHist;

  int total = 0;
  int bad = 0;
  int expCode = 20;

  always #10 clk = ~clk;

  freqTuner #(.NUM_EP(NEP), .SYNC_STAGES(2), .STAB_STAGES(2), .CODE_W(CW),
              .CLEAN_CYCLES(16), .INIT_CODE(20)) uut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .clrMask(clrMask), .minCode(minCode),
    .maxCode(maxCode), .replayDone(replayDone), .freqCode(freqCode),
    .replayReq(replayReq), .halfRate(halfRate), .stickyHist(stickyHist));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle error pulse, returns one negedge before the outputs move
  task automatic pulsePre(input logic [NEP-1:0] m);
    @(negedge clk) errIn = m;
    @(negedge clk) errIn = '0;
    tick(3);
  endtask

  task automatic pinMax();
    maxCode = CW'(expCode);
  endtask

  task automatic pulseReplayDone();
    @(negedge clk) replayDone = 1'b1;
    @(negedge clk) replayDone = 1'b0;
  endtask

  task automatic testReset();
    chk("R10 code", int'(freqCode), 20);
    chk("R10 replayReq", int'(replayReq), 0);
    chk("R10 halfRate", int'(halfRate), 0);
    chk("R10 sticky", int'(stickyHist), 0);
  endtask

  task automatic testLatency();
    pulsePre(4'b0010);
    chk("R1 code before edge 5", int'(freqCode), 20);
    chk("R1 replayReq before edge 5", int'(replayReq), 0);
    tick(1);
    chk("R1 code at edge 5", int'(freqCode), 19);
    chk("R6 replayReq with step", int'(replayReq), 1);
    chk("R7 halfRate set", int'(halfRate), 1);
    chk("R8 sticky endpoint 1", int'(stickyHist), 2);
    expCode = 19; pinMax();
    tick(1);
    chk("R6 replayReq one cycle", int'(replayReq), 0);
    chk("R7 halfRate held", int'(halfRate), 1);
    pulseReplayDone();
    chk("R7 halfRate cleared by done", int'(halfRate), 0);
  endtask

  task automatic testMerge();
    pulsePre(4'b1100);
    tick(1);
    chk("R2 one step for two endpoints", int'(freqCode), 18);
    chk("R8 sticky merge", int'(stickyHist), 4'b1110);
    expCode = 18; pinMax();
    tick(1);
    chk("R6 single replay for merged", int'(replayReq), 0);
  endtask

  task automatic testBurst();
    @(negedge clk) errIn = 4'b0001;
    tick(3);
    errIn = '0;
    tick(2);
    chk("R3 burst first step", int'(freqCode), 17);
    chk("R6 burst replay 1", int'(replayReq), 1);
    tick(1);
    chk("R3 burst second step", int'(freqCode), 16);
    tick(1);
    chk("R3 burst third step", int'(freqCode), 15);
    chk("R6 burst replay 3", int'(replayReq), 1);
    chk("R7 errors during replay lower code", int'(halfRate), 1);
    expCode = 15; pinMax();
    tick(1);
    chk("R6 burst replay ends", int'(replayReq), 0);
    chk("R8 sticky all", int'(stickyHist), 4'b1111);
    pulseReplayDone();
    chk("R7 halfRate cleared", int'(halfRate), 0);
  endtask

  task automatic testSetWins();
    @(negedge clk) errIn = 4'b0100;
    @(negedge clk) errIn = '0;
    tick(3);
    replayDone = 1'b1;
    @(negedge clk) replayDone = 1'b0;
    chk("R7 error beats done", int'(halfRate), 1);
    chk("R3 code during replay", int'(freqCode), 14);
    expCode = 14; pinMax();
    tick(1);
    chk("R7 still half rate", int'(halfRate), 1);
    pulseReplayDone();
    chk("R7 half rate off", int'(halfRate), 0);
  endtask

  task automatic testFloor();
    minCode = CW'(14);
    pulsePre(4'b0001);
    tick(1);
    chk("R5 floor blocks step", int'(freqCode), 14);
    chk("R6 replay at floor", int'(replayReq), 1);
    minCode = CW'(4);
    pulseReplayDone();
  endtask

  task automatic testStepUp();
    pulsePre(4'b0001);
    tick(1);
    chk("R3 step before climb", int'(freqCode), 13);
    maxCode = CW'(16);
    tick(15);
    chk("R4 no climb at 15 clean", int'(freqCode), 13);
    tick(1);
    chk("R4 climb at 16 clean", int'(freqCode), 14);
    tick(16);
    chk("R4 second climb", int'(freqCode), 15);
    tick(16);
    chk("R4 third climb", int'(freqCode), 16);
    tick(16);
    chk("R5 ceiling blocks climb", int'(freqCode), 16);
    tick(8);
    pulsePre(4'b0010);
    tick(1);
    chk("R3 step mid run", int'(freqCode), 15);
    tick(15);
    chk("R4 count restarted by error", int'(freqCode), 15);
    tick(1);
    chk("R4 climb after restart", int'(freqCode), 16);
    expCode = 16; pinMax();
    pulseReplayDone();
  endtask

  task automatic testStickyClear();
    @(negedge clk) clrMask = 4'b0101;
    @(negedge clk) clrMask = '0;
    chk("R9 masked clear", int'(stickyHist), 4'b1010);
    @(negedge clk) errIn = 4'b1000;
    @(negedge clk) errIn = '0;
    tick(3);
    clrMask = 4'b1000;
    @(negedge clk) clrMask = '0;
    chk("R9 new error beats clear", int'(stickyHist), 4'b1010);
    expCode = 15; pinMax();
    @(negedge clk) clrMask = 4'b1010;
    @(negedge clk) clrMask = '0;
    chk("R9 clear all set bits", int'(stickyHist), 0);
    chk("R8 no spurious set", int'(freqCode), 15);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testLatency();
    testMerge();
    testBurst();
    testSetWins();
    testFloor();
    testStepUp();
    testStickyClear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule